// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel data words into asynchronous serial frames on a single output line. A producer offers a word with a valid/ready handshake. While the transmitter is idle it takes the word, sends one frame, and then becomes ready for the next word. A frame is a low start bit, a data field sent least significant bit first, an optional parity bit, and a high stop field. The line rests high between frames.

The frame format is chosen at run time through plain configuration inputs: the data field length (5 to 8 bits), parity on or off, even or odd parity, a stop field of one, one and a half or two bit times, and a 16-bit bit-period count in clock cycles. For example, 9600 baud from a 50 MHz clock uses a count of 5208. The block samples all of these inputs together with the data word when it takes the word, so the surrounding register logic may change them at any moment. A busy output stays high for the whole frame. Storage of pending words and software-visible registers are not part of this block.

Top module: `serial_frame_tx`

## Requirements
- R1: `in_ready` is high exactly when `tx_busy` is low. A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high, and only then. `tx_busy` rises on that edge and falls on the edge that ends the last stop cycle, which leaves exactly one cycle with `tx_busy` low before a word that is held valid can be taken.
- R2: Out of reset, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1. `tx_line` is 1 in every cycle where `tx_busy` is 0.
- R3: Every frame starts with a single start bit, a 0 on `tx_line` lasting one bit period. It begins in the first cycle after the accepting edge.
- R4: After the start bit, the data field is sent least significant bit first. Its length is 8 − `cfg_len_code`: code 0 gives 8 bits, 1 gives 7, 2 gives 6 and 3 gives 5. Data bits above that length are not sent.
- R5: When `cfg_par_en` is 1, one parity bit follows the data field. With `cfg_par_odd` = 0 the data bits plus the parity bit hold an even number of ones; with `cfg_par_odd` = 1 they hold an odd number. When `cfg_par_en` is 0 no parity bit is sent and `cfg_par_odd` has no effect.
- R6: The frame ends with `tx_line` at 1 for a stop field whose length depends on `cfg_stop_sel`. Code 0 gives P cycles, code 1 gives P + floor(P/2) cycles, and codes 2 and 3 give 2P cycles, where P is the bit-period count.
- R7: The start bit, each data bit and the parity bit each last exactly `cfg_period` clock cycles, for any count from 2 up to 65535.
- R8: The data word and all configuration inputs are captured on the accepting edge. Changes to them while a frame is in progress have no effect on that frame.
- R9: With all format inputs at zero (`cfg_len_code`, `cfg_par_en`, `cfg_par_odd`, `cfg_stop_sel`), a frame carries 8 data bits, no parity bit and one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data word is offered |
| in_ready | output | 1 | The transmitter can take a word this cycle |
| in_data | input | 8 | Data word; bit 0 is sent first |
| cfg_len_code | input | 2 | Data field length code, bits = 8 − code |
| cfg_par_en | input | 1 | Adds a parity bit after the data field |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_stop_sel | input | 2 | Stop field length: 0 one, 1 one and a half, 2/3 two bit periods |
| cfg_period | input | 16 | Bit period in clock cycles, at least 2 |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | High while a frame is being sent |

## Verification
The assertions assume that `cfg_period` is at least 2 whenever a word is taken. With a smaller count the segment timer would see a zero-length segment and the count-down property would no longer describe a whole bit. The stimulus only uses bit periods of 2 or more, from 2 to 1000 cycles, so it covers the shortest legal bit and the rounding of the one-and-a-half stop field for odd counts. It changes the data and configuration inputs freely after each accepting edge, because the design is expected to ignore them until the next word is taken. It also keeps `in_valid` high across frame boundaries, so the assertions on the handshake see a word offered during a frame that must wait for the single idle cycle.

// File: rtl/serial_frame_tx_pkg.sv
// Package: shared definitions for the serial frame transmitter.
// Holds the sequencer state type and the stop field length codes.
// Assumes the data field length code is 2 bits wide.
package serial_frame_tx_pkg;

    // Sequencer states, one per frame segment plus idle.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    // Stop field length codes; any other code selects two periods.
    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;
    localparam logic [1:0] STOP_TWO      = 2'd2;

endpackage

// File: rtl/serial_frame_tx_timer.sv
// Module: segment timer.
// Down-counter that is loaded with (segment length - 1) at the start of a
// segment. It reports expiry when it reaches zero, so a segment loaded with
// value V lasts V + 1 cycles. Assumes load values are computed by the caller.
module serial_frame_tx_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new segment length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    // R7: without a reload, a running count drops by exactly one each cycle.
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7: a reload takes effect on the next cycle.
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/serial_frame_tx_shift.sv
// Module: data shifter and parity generator.
// Captures the word on load and computes the parity over the bits that the
// length code keeps. Shifts right on request, so bit 0 is always the bit on
// the line. Assumes load and shift are never high together.
module serial_frame_tx_shift #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_code,
    input  logic              par_odd,
    output logic              ser_bit,
    output logic              par_bit
);

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;

    // Mask of the data bits that belong to the field for this length code.
    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep_mask[i] = (i < (DATA_W - int'(len_code)));
    end

    // Capture the word and its parity, or step to the next data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else if (load) begin
            shreg_q <= din;
            par_q   <= (^(din & keep_mask)) ^ par_odd;
        end else if (shift) begin
            shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
        end
    end

    assign ser_bit = shreg_q[0];
    assign par_bit = par_q;

endmodule

// File: rtl/serial_frame_tx_ctrl.sv
// Module: frame sequencer.
// Walks through the start, data, parity and stop segments, and drives the
// line and the busy flag. It captures the format and the period when it takes
// a word, and keeps them for the whole frame. Assumes cfg_period >= 2.
module serial_frame_tx_ctrl
    import serial_frame_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 2,
    parameter int PERIOD_W = 16,
    parameter int CNT_W    = PERIOD_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                accept,
    input  logic [CODE_W-1:0]   cfg_len_code,
    input  logic                cfg_par_en,
    input  logic [1:0]          cfg_stop_sel,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                tmr_expired,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_val,
    output logic                sh_shift,
    input  logic                sh_bit,
    input  logic                par_bit,
    output logic                tx_line,
    output logic                tx_busy
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e           state_q, state_d;
    logic                busy_q, busy_d;
    logic [BIT_W-1:0]    bits_q, bits_d;
    logic [CODE_W-1:0]   len_q;
    logic                par_en_q;
    logic [1:0]          stop_q;
    logic [PERIOD_W-1:0] period_q;
    logic [CNT_W-1:0]    per_m1;
    logic [CNT_W-1:0]    stop_m1;

    // Segment length minus one for one bit period and for the stop field.
    always_comb begin
        per_m1 = CNT_W'(period_q) - CNT_W'(1);
        unique case (stop_q)
            STOP_ONE:      stop_m1 = per_m1;
            STOP_ONE_HALF: stop_m1 = per_m1 + CNT_W'(period_q >> 1);
            default:       stop_m1 = {period_q, 1'b0} - CNT_W'(1);
        endcase
    end

    // Next-state logic: move to the next segment when the timer expires.
    always_comb begin
        state_d  = state_q;
        busy_d   = busy_q;
        bits_d   = bits_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = per_m1;
        sh_shift = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    accept   = 1'b1;
                    busy_d   = 1'b1;
                    state_d  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(cfg_period) - CNT_W'(1);
                end
            end
            ST_START: begin
                if (tmr_expired) begin
                    state_d  = ST_DATA;
                    tmr_load = 1'b1;
                    bits_d   = BIT_W'(DATA_W - 1 - int'(len_q));
                end
            end
            ST_DATA: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (bits_q == '0) begin
                        if (par_en_q) begin
                            state_d = ST_PAR;
                        end else begin
                            state_d = ST_STOP;
                            tmr_val = stop_m1;
                        end
                    end else begin
                        sh_shift = 1'b1;
                        bits_d   = bits_q - BIT_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (tmr_expired) begin
                    state_d  = ST_STOP;
                    tmr_load = 1'b1;
                    tmr_val  = stop_m1;
                end
            end
            ST_STOP: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    busy_d  = 1'b0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                busy_d  = 1'b0;
            end
        endcase
    end

    // Sequencer state, busy flag and data bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            busy_q  <= busy_d;
            bits_q  <= bits_d;
        end
    end

    // Frame format captured on acceptance; resets to 8 data bits, no parity, 1 stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            par_en_q <= 1'b0;
            stop_q   <= STOP_ONE;
            period_q <= '0;
        end else if (accept) begin
            len_q    <= cfg_len_code;
            par_en_q <= cfg_par_en;
            stop_q   <= cfg_stop_sel;
            period_q <= cfg_period;
        end
    end

    // Line level for the current segment.
    always_comb begin
        unique case (state_q)
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = sh_bit;
            ST_PAR:   tx_line = par_bit;
            default:  tx_line = 1'b1;
        endcase
    end

    assign in_ready = (state_q == ST_IDLE);
    assign tx_busy  = busy_q;

    // R1: ready and busy are always opposite.
    p_ready_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != tx_busy);

    // R1: busy only rises after a word was offered.
    p_take_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(in_valid));

    // R2: the line rests high when no frame is in progress.
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    // R3: taking a word drives the start bit on the next cycle.
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!tx_line && tx_busy));

    // R6: the last frame cycle before busy drops is a stop cycle.
    p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(tx_line));

    // R8: the captured period does not move while a frame runs.
    p_fmt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(period_q));

endmodule

// File: rtl/serial_frame_tx.sv
// Module: configurable asynchronous serial transmitter (top).
// Takes a word over a valid/ready handshake and sends one frame made of a
// start bit, 5..8 data bits (LSB first), an optional parity bit and a stop
// field of 1, 1.5 or 2 periods. Assumes cfg_period >= 2.
module serial_frame_tx #(
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 2,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [CODE_W-1:0]   cfg_len_code,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic [1:0]          cfg_stop_sel,
    input  logic [PERIOD_W-1:0] cfg_period,
    output logic                tx_line,
    output logic                tx_busy
);

    localparam int CNT_W = PERIOD_W + 1;

    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sh_shift;
    logic             sh_bit;
    logic             par_bit;

    serial_frame_tx_ctrl #(
        .DATA_W  (DATA_W),
        .CODE_W  (CODE_W),
        .PERIOD_W(PERIOD_W),
        .CNT_W   (CNT_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .accept      (accept),
        .cfg_len_code(cfg_len_code),
        .cfg_par_en  (cfg_par_en),
        .cfg_stop_sel(cfg_stop_sel),
        .cfg_period  (cfg_period),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sh_shift    (sh_shift),
        .sh_bit      (sh_bit),
        .par_bit     (par_bit),
        .tx_line     (tx_line),
        .tx_busy     (tx_busy)
    );

    serial_frame_tx_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    serial_frame_tx_shift #(
        .DATA_W(DATA_W),
        .CODE_W(CODE_W)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (sh_shift),
        .din     (in_data),
        .len_code(cfg_len_code),
        .par_odd (cfg_par_odd),
        .ser_bit (sh_bit),
        .par_bit (par_bit)
    );

endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
// Bench: scoreboard for the serial frame transmitter. The driver task queues
// the expected frame for every word it hands over; the monitor pops one item
// per start bit and checks every cycle of the frame at the negative edge.
module test_serial_frame_tx;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         pe;
        bit         par;
        int         per;
        int         stp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic [1:0]  cfg_len_code = '0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic [1:0]  cfg_stop_sel = '0;
    logic [15:0] cfg_period = 16'd2;
    logic        tx_line;
    logic        tx_busy;

    int   checks = 0;
    int   errors = 0;
    int   sent = 0;
    int   done_frames = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .cfg_len_code(cfg_len_code),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop_sel(cfg_stop_sel),
        .cfg_period  (cfg_period),
        .tx_line     (tx_line),
        .tx_busy     (tx_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: offer one word, wait for the handshake, queue the expected frame.
    task automatic send(input logic [7:0] d, input logic [1:0] lc, input bit pe,
                        input bit po, input logic [1:0] ss, input int per,
                        input bit hold_valid);
        exp_t e;
        @(negedge clk);
        in_valid     = 1'b1;
        in_data      = d;
        cfg_len_code = lc;
        cfg_par_en   = pe;
        cfg_par_odd  = po;
        cfg_stop_sel = ss;
        cfg_period   = 16'(per);
        while (in_ready !== 1'b1) @(negedge clk);
        e.d   = d;
        e.nb  = 8 - int'(lc);
        e.pe  = pe;
        e.par = ^(d & 8'((1 << e.nb) - 1)) ^ po;
        e.per = per;
        e.stp = (ss == 2'd0) ? per : (ss == 2'd1) ? per + per / 2 : 2 * per;
        q.push_back(e);
        sent++;
        @(negedge clk);
        // R1: the word was taken, so busy is up and ready is down.
        chk(tx_busy === 1'b1 && in_ready === 1'b0, "R1 busy after accept",
            int'({tx_busy, in_ready}), 2);
        if (!hold_valid) begin
            // R8: scramble every input while the frame runs.
            in_valid     = 1'b0;
            in_data      = ~d;
            cfg_len_code = ~lc;
            cfg_par_en   = ~pe;
            cfg_par_odd  = ~po;
            cfg_stop_sel = ~ss;
            cfg_period   = 16'(per + 3);
        end
    endtask

    // Monitor helper: check a segment of the line, cycle by cycle.
    task automatic span(input logic lvl, input int len, input int first, input string req);
        bit   ok = 1'b1;
        logic bad = lvl;
        for (int c = first; c < len; c++) begin
            @(negedge clk);
            if (tx_line !== lvl || tx_busy !== 1'b1) begin
                if (ok) bad = tx_line;
                ok = 1'b0;
            end
        end
        chk(ok, req, int'(bad), int'(lvl));
    endtask

    // Monitor: a low line while idle marks the start of the next frame.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst_n || tx_line !== 1'b0) continue;
            if (q.size() == 0) begin
                chk(1'b0, "R1 unexpected frame", 1, 0);
                continue;
            end
            e = q.pop_front();
            span(1'b0, e.per, 1, "R3 start bit R7");
            for (int i = 0; i < e.nb; i++) span(e.d[i], e.per, 0, "R4 data bit R7");
            if (e.pe) span(e.par, e.per, 0, "R5 parity bit");
            span(1'b1, e.stp, 0, "R6 stop field");
            @(negedge clk);
            // R1: exactly one idle cycle after the stop field.
            chk(tx_busy === 1'b0 && in_ready === 1'b1 && tx_line === 1'b1,
                "R1 idle after stop", int'({tx_busy, in_ready, tx_line}), 3);
            done_frames++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d frames", done_frames, sent);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state.
        chk(tx_line === 1'b1, "R2 reset line", int'(tx_line), 1);
        chk(tx_busy === 1'b0, "R2 reset busy", int'(tx_busy), 0);
        chk(in_ready === 1'b1, "R2 reset ready", int'(in_ready), 1);

        send(8'hA5, 2'd0, 1'b0, 1'b0, 2'd0, 4, 1'b0);     // R9 all-zero format
        send(8'hF3, 2'd3, 1'b1, 1'b0, 2'd0, 3, 1'b0);     // R4 five bits, R5 even
        send(8'h2D, 2'd2, 1'b1, 1'b1, 2'd1, 5, 1'b0);     // R5 odd, R6 1.5 with odd P
        send(8'h6E, 2'd1, 1'b1, 1'b0, 2'd2, 2, 1'b0);     // R6 two stop, R7 shortest P
        send(8'h00, 2'd0, 1'b1, 1'b1, 2'd1, 2, 1'b0);     // R6 1.5 at P=2, R5 odd of zero
        send(8'hFF, 2'd0, 1'b0, 1'b1, 2'd3, 6, 1'b0);     // R5 odd ignored, R6 code 3
        send(8'h81, 2'd3, 1'b0, 1'b0, 2'd1, 7, 1'b0);     // R4 upper bits dropped
        // R1 R8: back-to-back with valid held and new words waiting while busy.
        send(8'h3C, 2'd0, 1'b1, 1'b0, 2'd0, 3, 1'b1);
        send(8'hC3, 2'd1, 1'b0, 1'b0, 2'd2, 4, 1'b1);
        send(8'h5A, 2'd2, 1'b1, 1'b1, 2'd1, 3, 1'b1);
        send(8'h96, 2'd0, 1'b1, 1'b0, 2'd1, 1000, 1'b0);  // R7 long period

        while (done_frames < sent) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            // R2: line stays high while idle.
            chk(tx_line === 1'b1 && tx_busy === 1'b0, "R2 idle line", int'(tx_line), 1);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule